// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block produces the byte addresses that a vector load or store unit needs to fetch or write a long vector whose elements are spaced evenly in memory. Software hands it a starting byte address, a signed element distance counted in 64-bit words, and the total number of elements. Every element is one 8-byte doubleword, so successive addresses differ by the distance times eight. A distance of zero repeats one address. A negative distance walks downward through memory. All addresses wrap modulo 2^32.

A vector register holds at most 64 elements, so the block cuts the vector into strips, one register fill per strip. The first strip takes the leftover part (the count modulo 64, or a full 64 when that leftover is zero). Every strip after it is exactly 64 elements long. Each address leaves the block with the register slot it belongs in, so elements that are far apart in memory land in adjacent slots 0, 1, 2 and so on. The block also flags the last element of every strip. Before the first address of each strip there is a start-up delay, and every strip after the first also pays a loop-overhead delay.

A request is accepted through a start/busy/done handshake. Addresses come out on a valid/ready stream. The memory side can stall the stream at any time by holding ready low.

Top module: `vec_stride_agen`

## Requirements
- R1: After reset, busy, done and address-valid are all low, and no address is offered.
- R2: A start pulse with a nonzero count, sampled while busy is low, raises busy at the next clock edge. Address-valid then rises after exactly STARTUP_CYC further edges, and busy stays high during that wait.
- R3: The address of global element i (counting from 0) equals base + i × stride × 8, taken modulo 2^32. The stride is a signed 16-bit two's-complement value.
- R4: The slot index is 0 for the first element of every strip and rises by one for each following element of that strip.
- R5: The first strip carries (count mod 64) elements, or 64 elements when that value is 0. Every later strip carries 64 elements. The total number of addresses issued equals the count.
- R6: strip_last is high exactly on the final element of each strip.
- R7: After the final element of a strip that is not the last strip, address-valid stays low for LOOP_CYC + STARTUP_CYC cycles while busy stays high. It then rises again.
- R8: While address-valid is high and ready is low, the address, slot and strip_last hold steady and valid stays high.
- R9: One cycle after the final element is accepted, done is high for one cycle with busy low. In the cycle after that, done is low.
- R10: A start with a count of 0 issues no addresses and raises done in the cycle after start.
- R11: A start pulse while busy is high is ignored: it changes neither the address sequence in progress nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a request; sampled only while busy is low |
| base_i | input | 32 | Byte address of element 0 |
| stride_i | input | 16 | Signed element distance in doublewords |
| count_i | input | 16 | Total number of elements |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| addr_valid_o | output | 1 | An address is offered |
| addr_ready_i | input | 1 | The consumer takes the offered address |
| addr_o | output | 32 | Byte address of the current element |
| slot_o | output | 6 | Register slot of the current element |
| strip_last_o | output | 1 | Current element closes its strip |

## Verification
The tests use counts that fall exactly on a strip (64), just past one (65, which gives a one-element first strip), in the middle of one (5, 10), and across several strips (130, 200). These separate a wrong first-strip length from a wrong later-strip length. Strides of +1, +2, +100, −3 and 0 separate correct sign extension and ×8 scaling from unsigned or unscaled arithmetic. A base just below 2^32 shows whether the address wraps correctly. Runs with ready always high measure the exact start-up and inter-strip delays, and runs with a pseudo-random ready show whether the address stream holds steady under back-pressure. A zero count and a start pulse sent in the middle of a run cover the two cases where the request is expected to produce nothing.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } vsa_state_e;

endpackage

// File: rtl/vsa_strip_plan.sv
// Length of the leading strip: leftover part of the count, or a full strip.
module vsa_strip_plan #(
    parameter int CNT_W     = 16,
    parameter int STRIP_MAX = 64,
    localparam int SLOT_W   = $clog2(STRIP_MAX)
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [SLOT_W:0]  first_len_o,
    output logic             empty_o
);
    logic [SLOT_W-1:0] rem;

    always_comb begin
        rem         = count_i[SLOT_W-1:0];
        empty_o     = (count_i == '0);
        first_len_o = (rem == '0) ? (SLOT_W+1)'(STRIP_MAX) : {1'b0, rem};
    end
endmodule

// File: rtl/vsa_addr_step.sv
// Sign-extended stride scaled to a byte step.
module vsa_addr_step #(
    parameter int ADDR_W     = 32,
    parameter int STRIDE_W   = 16,
    parameter int ELEM_SHIFT = 3,
    localparam int SCALED_W  = STRIDE_W + ELEM_SHIFT
) (
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [ADDR_W-1:0]   step_o
);
    logic [SCALED_W-1:0] scaled;

    assign scaled = {stride_i, {ELEM_SHIFT{1'b0}}};

    generate
        if (ADDR_W > SCALED_W) begin : g_extend
            assign step_o = {{(ADDR_W-SCALED_W){scaled[SCALED_W-1]}}, scaled};
        end else begin : g_trunc
            assign step_o = scaled[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/vec_stride_agen.sv
module vec_stride_agen #(
    parameter int ADDR_W      = 32,
    parameter int STRIDE_W    = 16,
    parameter int CNT_W       = 16,
    parameter int STRIP_MAX   = 64,
    parameter int ELEM_SHIFT  = 3,
    parameter int STARTUP_CYC = 4,
    parameter int LOOP_CYC    = 1,
    localparam int SLOT_W     = $clog2(STRIP_MAX),
    localparam int GAP_CYC    = STARTUP_CYC + LOOP_CYC,
    localparam int TMR_W      = $clog2(GAP_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [CNT_W-1:0]    count_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                addr_valid_o,
    input  logic                addr_ready_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic                strip_last_o
);
    import vsa_pkg::*;

    typedef struct packed {
        vsa_state_e          st;
        logic [TMR_W-1:0]    tmr;
        logic [ADDR_W-1:0]   addr;
        logic [STRIDE_W-1:0] stride;
        logic [SLOT_W-1:0]   slot;
        logic [SLOT_W:0]     len;
        logic [CNT_W-1:0]    left;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [SLOT_W:0]   first_len;
    logic              cnt_empty;
    logic [ADDR_W-1:0] step;
    logic              at_strip_end;

    vsa_strip_plan #(.CNT_W(CNT_W), .STRIP_MAX(STRIP_MAX)) plan_i (
        .count_i     (count_i),
        .first_len_o (first_len),
        .empty_o     (cnt_empty)
    );

    vsa_addr_step #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ELEM_SHIFT(ELEM_SHIFT)) step_i (
        .stride_i (r_q.stride),
        .step_o   (step)
    );

    assign at_strip_end = ({1'b0, r_q.slot} == (r_q.len - 1'b1));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                r_d.st = ST_IDLE;
                if (start_i) begin
                    if (cnt_empty) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st     = ST_WAIT;
                        r_d.tmr    = TMR_W'(STARTUP_CYC);
                        r_d.addr   = base_i;
                        r_d.stride = stride_i;
                        r_d.slot   = '0;
                        r_d.len    = first_len;
                        r_d.left   = count_i;
                    end
                end
            end
            ST_WAIT: begin
                if (r_q.tmr <= TMR_W'(1)) begin
                    r_d.st = ST_ISSUE;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_ISSUE: begin
                if (addr_ready_i) begin
                    r_d.addr = r_q.addr + step;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == CNT_W'(1)) begin
                        r_d.st = ST_DONE;
                    end else if (at_strip_end) begin
                        r_d.st   = ST_WAIT;
                        r_d.tmr  = TMR_W'(GAP_CYC);
                        r_d.slot = '0;
                        r_d.len  = (SLOT_W+1)'(STRIP_MAX);
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, tmr: '0, addr: '0, stride: '0,
                     slot: '0, len: '0, left: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st == ST_WAIT) || (r_q.st == ST_ISSUE);
    assign done_o       = (r_q.st == ST_DONE);
    assign addr_valid_o = (r_q.st == ST_ISSUE);
    assign addr_o       = r_q.addr;
    assign slot_o       = r_q.slot;
    assign strip_last_o = (r_q.st == ST_ISSUE) && at_strip_end;
endmodule

// File: rtl/vsa_agen_chk.sv
module vsa_agen_chk #(
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              addr_valid_o,
    input logic              addr_ready_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic              strip_last_o
);
    // R8: offered address is frozen under back-pressure
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o && !addr_ready_i |=>
            addr_valid_o && $stable(addr_o) && $stable(slot_o) && $stable(strip_last_o));

    // R4: slot advances by one inside a strip
    a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o && addr_ready_i && !strip_last_o |=>
            addr_valid_o && (slot_o == SLOT_W'($past(slot_o) + 1'b1)));

    // R4: every strip opens at slot 0
    a_r4_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid_o) |-> (slot_o == '0));

    // R7: a strip end is followed by a gap
    a_r7_gap_after_strip: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o && addr_ready_i && strip_last_o |=> !addr_valid_o);

    // R9: done never overlaps activity
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !addr_valid_o);

    // R2: addresses only appear while busy
    a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> busy_o);
endmodule

bind vec_stride_agen vsa_agen_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .addr_o       (addr_o),
    .slot_o       (slot_o),
    .strip_last_o (strip_last_o)
);

// File: tb/vec_stride_agen_tb_top.sv
`timescale 1ns/1ps
module vec_stride_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] stride = '0;
    logic [15:0] count = '0;
    logic        busy, done, valid, strip_last;
    logic        ready = 1'b1;
    logic [31:0] addr;
    logic [5:0]  slot;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  rdy_rand = 1'b0;
    bit  fin_seen = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    typedef struct {
        logic [31:0] a;
        int          s;
        bit          last;
        bit          fin;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    vec_stride_agen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base),
        .stride_i(stride), .count_i(count), .busy_o(busy), .done_o(done),
        .addr_valid_o(valid), .addr_ready_i(ready), .addr_o(addr),
        .slot_o(slot), .strip_last_o(strip_last)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // back-pressure generator
    always begin
        @(posedge clk);
        #1;
        if (rdy_rand) begin
            lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ready = lfsr[0] | lfsr[2];
        end else begin
            ready = 1'b1;
        end
    end

    // monitor / scoreboard
    int          fin_st = 0;
    bit          gap_on = 1'b0;
    int          gap_cnt = 0;
    bit          hold_on = 1'b0;
    logic [31:0] hold_a;
    logic [5:0]  hold_s;

    always @(negedge clk) begin
        if (rst_n) begin
            if (fin_st == 1) begin
                chk(done && !busy, "R9 done pulse after final element", {done, busy}, 2'b10);
                fin_st = 2;
            end else if (fin_st == 2) begin
                chk(!done, "R9 done lasts one cycle", done, 0);
                fin_st   = 0;
                fin_seen = 1'b1;
            end
            if (gap_on) begin
                if (valid) begin
                    chk(gap_cnt == 5, "R7 inter-strip gap length", gap_cnt, 5);
                    gap_on = 1'b0;
                end else begin
                    chk(busy, "R7 busy during gap", busy, 1);
                    gap_cnt++;
                end
            end
            if (hold_on) begin
                chk(valid && addr == hold_a && slot == hold_s, "R8 stall hold addr",
                    addr, hold_a);
                hold_on = 1'b0;
            end
            if (valid && !ready) begin
                hold_on = 1'b1;
                hold_a  = addr;
                hold_s  = slot;
            end
            if (valid && ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 address beyond count", addr, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(addr == it.a, "R3 address", addr, it.a);
                    chk(int'(slot) == it.s, "R4 slot", slot, it.s);
                    chk(strip_last == it.last, "R6 strip_last", strip_last, it.last);
                    if (it.fin) fin_st = 1;
                    if (it.last && !it.fin) begin
                        gap_on  = 1'b1;
                        gap_cnt = 0;
                    end
                end
            end
        end
    end

    task automatic run_vec(input logic [31:0] b, input logic [15:0] st, input int n,
                           input bit rnd, input bit poke);
        int first, sidx, len, k;
        int s;
        item_t it;
        s     = int'($signed(st));
        first = (n % 64 == 0) ? 64 : n % 64;
        for (int i = 0; i < n; i++) begin
            if (i < first) begin
                sidx = i;
                len  = first;
            end else begin
                sidx = (i - first) % 64;
                len  = 64;
            end
            it.a    = b + 32'(i * s * 8);
            it.s    = sidx;
            it.last = (sidx == len - 1);
            it.fin  = (i == n - 1);
            q.push_back(it);
        end
        fin_seen = 1'b0;
        rdy_rand = rnd;
        @(posedge clk); #1;
        base = b; stride = st; count = 16'(n); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (n == 0) begin
            @(negedge clk);
            chk(done && !valid && !busy, "R10 zero count done next cycle", {done, valid, busy}, 3'b100);
            @(negedge clk);
            chk(!done && !valid, "R10 zero count no addresses", {done, valid}, 0);
            return;
        end
        k = 0;
        @(negedge clk);
        chk(busy, "R2 busy after start", busy, 1);
        while (!valid) begin
            k++;
            @(negedge clk);
        end
        chk(k == 4, "R2 start-up latency", k, 4);
        if (poke) begin
            @(posedge clk); #1;
            base = 32'hDEAD_0000; stride = 16'h0007; count = 16'd3; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            @(negedge clk);
            chk(busy, "R11 start while busy ignored", busy, 1);
        end
        while (!fin_seen) @(negedge clk);
        chk(q.size() == 0, "R5 all elements issued", q.size(), 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !valid, "R1 reset state", {busy, done, valid}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !valid, "R1 idle after reset", {busy, done, valid}, 0);

        run_vec(32'h0000_1000, 16'd1,   5,   1'b0, 1'b0);
        run_vec(32'h0000_8000, 16'd100, 64,  1'b0, 1'b0);
        run_vec(32'h0002_0000, -16'sd3, 130, 1'b1, 1'b1);
        run_vec(32'h0000_0040, 16'd5,   0,   1'b0, 1'b0);
        run_vec(32'hFFFF_FFF0, 16'd1,   10,  1'b0, 1'b0);
        run_vec(32'h0000_0400, 16'd0,   200, 1'b0, 1'b0);
        run_vec(32'h0000_0100, 16'd2,   65,  1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule